// File: doc/BRIEF.md
# Debug Transport Bus Scan Register

This block sits behind a test access port and holds two data registers that the host reaches through serial scans. The first is a 32-bit read-only info register that tells the host how wide the debug bus address is and which transport revision it talks to. The second is a combined bus scan register. Each scan carries an operation code, a 34-bit data word and an address into the block. The same scan carries the outcome of the previous access back out.

On every capture, the bus scan register loads the status and data of the request that the previous scan launched. On every update, it launches a new request on a simple request/response debug bus toward a debug module. Only one request can be in flight. A read therefore needs a second scan to collect its value. A scan that arrives while a request is still open reads back a busy code and is discarded, so the host must repeat it. Instruction decode and the state machine of the test access port are outside the block. The block sees them as two select lines plus capture, shift and update strobes.

Top module: `dtm_scan_port`

## Requirements
- R1: With the info register selected, a capture loads 32 bits: the address width in bits [7:4], the transport version in bits [3:0], and zero in all other bits. Shifting then presents them on tdo, least significant bit first.
- R2: The bus scan register is ADDR_W+36 bits long, with op in bits [1:0], data in bits [35:2] and address in bits [ADDR_W+35:36]. Each shift moves the register one place toward bit 0, drives tdo from bit 0 and enters tdi at the top bit. On capture, the address field holds the address of the most recently launched request.
- R3: An update with op 1 (read) issues exactly one request. req_valid is high for one cycle, starting the cycle after the update, with req_write=0 and the scanned address.
- R4: An update with op 2 (write) issues one request with req_write=1, req_cond=0, and the scanned address and data.
- R5: An update with op 3 (conditional write) issues a request with req_write=1 and req_cond=1. If the response declines it (rsp_nowrite), the next capture reports status 1.
- R6: When a request completes, the next capture reports status 0 on success or status 2 if rsp_fail was set, and its data field holds rsp_data of that response.
- R7: A capture while a request is open reports status 3 (busy). The update of a scan that captured busy, or of a scan that arrives while a request is open, issues no request and is dropped.
- R8: An update with op 0 (no-op) issues no request. Later captures keep returning the result of the last completed request unchanged.
- R9: After reset, no request is open, req_valid is low, and a capture returns status 0, data 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| sel_info | input | 1 | Info register selected |
| sel_scan | input | 1 | Bus scan register selected |
| dr_capture | input | 1 | Capture strobe |
| dr_shift | input | 1 | Shift strobe |
| dr_update | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| req_valid | output | 1 | One-cycle request pulse |
| req_write | output | 1 | Request is a write |
| req_cond | output | 1 | Write is conditional |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | 34 | Request data |
| rsp_valid | input | 1 | Response pulse |
| rsp_data | input | 34 | Response data |
| rsp_fail | input | 1 | Request failed |
| rsp_nowrite | input | 1 | Conditional write declined |

## Verification
The bench uses the default ADDR_W of 6, so a scan is 42 bits long. The all-ones address 0x3F is reachable, and the bench's responder treats it as the failing address. Responder latency is switched between a few cycles and 120 cycles. The long setting is longer than a whole scan, so the busy path, the dropped update and the repeated scan can all be reached in one run. The short setting exercises back-to-back results.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
    localparam int DATA_W = 34;
    localparam int HDR_W  = DATA_W + 2;
    localparam int INFO_W = 32;

    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_CWRITE = 2'd3
    } dtm_op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NOWRITE = 2'd1,
        RES_FAIL    = 2'd2,
        RES_BUSY    = 2'd3
    } dtm_res_e;
endpackage

// File: rtl/dtm_shift_reg.sv
module dtm_shift_reg #(
    parameter int W      = 42,
    parameter int INFO_W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic         shift_i,
    input  logic         narrow_i,
    input  logic [W-1:0] cap_val_i,
    input  logic         tdi_i,
    output logic         tdo_o,
    output logic [W-1:0] sr_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } sr_state_t;

    sr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i) begin
            st_d.sr = cap_val_i;
        end else if (shift_i) begin
            st_d.sr = st_q.sr >> 1;
            if (narrow_i) begin
                st_d.sr[INFO_W-1] = tdi_i;
            end else begin
                st_d.sr[W-1] = tdi_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tdo_o = st_q.sr[0];
    assign sr_o  = st_q.sr;
endmodule

// File: rtl/dtm_bus_ctrl.sv
module dtm_bus_ctrl
    import dtm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  dtm_op_e           op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              rsp_fail_i,
    input  logic              rsp_nowrite_i,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic              req_cond_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    output logic              pend_o,
    output dtm_res_e          result_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic              pend;
        logic              req_valid;
        logic              write;
        logic              cond;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        dtm_res_e          result;
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    bus_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.req_valid = 1'b0;
        if (launch_i && op_i != OP_NOP) begin
            st_d.pend      = 1'b1;
            st_d.req_valid = 1'b1;
            st_d.write     = op_i[1];
            st_d.cond      = (op_i == OP_CWRITE);
            st_d.addr      = addr_i;
            st_d.wdata     = wdata_i;
        end
        if (rsp_valid_i && st_q.pend) begin
            st_d.pend  = 1'b0;
            st_d.rdata = rsp_data_i;
            if (rsp_fail_i) begin
                st_d.result = RES_FAIL;
            end else if (rsp_nowrite_i && st_q.cond) begin
                st_d.result = RES_NOWRITE;
            end else begin
                st_d.result = RES_OK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pend: 1'b0, req_valid: 1'b0, write: 1'b0, cond: 1'b0,
                      addr: '0, wdata: '0, result: RES_OK, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid_o = st_q.req_valid;
    assign req_write_o = st_q.write;
    assign req_cond_o  = st_q.cond;
    assign req_addr_o  = st_q.addr;
    assign req_wdata_o = st_q.wdata;
    assign pend_o      = st_q.pend;
    assign result_o    = st_q.result;
    assign rdata_o     = st_q.rdata;
endmodule

// File: rtl/dtm_scan_port.sv
module dtm_scan_port
    import dtm_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int VERSION = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_info,
    input  logic              sel_scan,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic              dr_update,
    input  logic              tdi,
    output logic              tdo,
    output logic              req_valid,
    output logic              req_write,
    output logic              req_cond,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_fail,
    input  logic              rsp_nowrite
);
    localparam int W = ADDR_W + HDR_W;

    typedef struct packed {
        logic cap_busy;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              pend;
    dtm_res_e          result;
    logic [DATA_W-1:0] rdata;
    logic [W-1:0]      scan_bits;
    logic [W-1:0]      cap_val;
    logic              any_sel;
    logic              launch;
    dtm_op_e           upd_op;

    assign any_sel = sel_info | sel_scan;
    assign upd_op  = dtm_op_e'(scan_bits[1:0]);

    always_comb begin
        st_d   = st_q;
        launch = 1'b0;
        if (dr_capture && sel_scan) begin
            st_d.cap_busy = pend;
        end
        if (dr_update && sel_scan && !st_q.cap_busy && !pend) begin
            launch = 1'b1;
        end
    end

    always_comb begin
        if (sel_info) begin
            cap_val      = '0;
            cap_val[7:4] = 4'(ADDR_W);
            cap_val[3:0] = 4'(VERSION);
        end else begin
            cap_val = {req_addr, rdata, (pend ? RES_BUSY : result)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dtm_shift_reg #(.W(W), .INFO_W(INFO_W)) u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (dr_capture & any_sel),
        .shift_i   (dr_shift & any_sel),
        .narrow_i  (sel_info),
        .cap_val_i (cap_val),
        .tdi_i     (tdi),
        .tdo_o     (tdo),
        .sr_o      (scan_bits)
    );

    dtm_bus_ctrl #(.ADDR_W(ADDR_W)) u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch_i      (launch),
        .op_i          (upd_op),
        .addr_i        (scan_bits[W-1:HDR_W]),
        .wdata_i       (scan_bits[HDR_W-1:2]),
        .rsp_valid_i   (rsp_valid),
        .rsp_data_i    (rsp_data),
        .rsp_fail_i    (rsp_fail),
        .rsp_nowrite_i (rsp_nowrite),
        .req_valid_o   (req_valid),
        .req_write_o   (req_write),
        .req_cond_o    (req_cond),
        .req_addr_o    (req_addr),
        .req_wdata_o   (req_wdata),
        .pend_o        (pend),
        .result_o      (result),
        .rdata_o       (rdata)
    );
endmodule

// File: rtl/dtm_scan_port_chk.sv
module dtm_scan_port_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_scan,
    input logic              dr_capture,
    input logic              dr_update,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_cond,
    input logic              rsp_valid,
    input logic              pend,
    input logic [ADDR_W+35:0] scan_bits
);
    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    assert_req_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> pend);

    assert_cond_is_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cond) |-> req_write);

    assert_rsp_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && pend) |=> !pend);

    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_update && sel_scan && pend) |=> !req_valid);

    assert_busy_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_capture && sel_scan && pend) |=> (scan_bits[1:0] == 2'b11));

    assert_nop_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_update && sel_scan && scan_bits[1:0] == 2'b00) |=> !req_valid);
endmodule

bind dtm_scan_port dtm_scan_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_scan   (sel_scan),
    .dr_capture (dr_capture),
    .dr_update  (dr_update),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_cond   (req_cond),
    .rsp_valid  (rsp_valid),
    .pend       (pend),
    .scan_bits  (scan_bits)
);

// File: tb/dtm_scan_port_test.sv
module dtm_scan_port_test;
    localparam int AW = 6;
    localparam int VER = 1;
    localparam int W = AW + 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_info = 1'b0, sel_scan = 1'b0;
    logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
    logic tdo, req_valid, req_write, req_cond;
    logic [AW-1:0] req_addr;
    logic [33:0] req_wdata;
    logic rsp_valid = 1'b0, rsp_fail = 1'b0, rsp_nowrite = 1'b0;
    logic [33:0] rsp_data = '0;

    int n_chk = 0, n_fail = 0, cyc = 0, latency = 3;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dtm_scan_port #(.ADDR_W(AW), .VERSION(VER)) uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [33:0] rd_val(input logic [AW-1:0] a);
        return 34'h2_0000_0000 | (34'(a) * 34'h0_0001_0203);
    endfunction

    // Behavioural reference model
    logic [1:0]    cur_op = '0;
    logic [33:0]   cur_data = '0;
    logic [AW-1:0] cur_addr = '0;
    bit            m_pend, m_capbusy, m_req, m_write, m_cond;
    logic [1:0]    m_res;
    logic [33:0]   m_data, m_wdata;
    logic [AW-1:0] m_addr;
    logic [W-1:0]  m_cap;
    int            m_nreq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_capbusy = 0; m_req = 0; m_write = 0; m_cond = 0;
            m_res = 0; m_data = 0; m_wdata = 0; m_addr = 0; m_cap = 0;
        end else begin
            m_req = 0;
            if (dr_capture && sel_scan) begin
                m_cap = {m_addr, m_data, (m_pend ? 2'd3 : m_res)};
                m_capbusy = m_pend;
            end
            if (dr_capture && sel_info) begin
                m_cap = '0;
                m_cap[7:0] = {4'(AW), 4'(VER)};
            end
            if (dr_update && sel_scan && !m_capbusy && !m_pend && cur_op != 2'd0) begin
                m_req = 1; m_pend = 1; m_nreq++;
                m_write = cur_op[1]; m_cond = (cur_op == 2'd3);
                m_addr = cur_addr; m_wdata = cur_data;
            end else if (rsp_valid && m_pend) begin
                m_pend = 0;
                m_data = rsp_data;
                m_res = rsp_fail ? 2'd2 : (rsp_nowrite && m_cond) ? 2'd1 : 2'd0;
            end
        end
    end

    // Per-clock comparison of the bus request outputs
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid !== m_req) chk(0, "R3 req_valid", 64'(req_valid), 64'(m_req));
            else if (m_req) begin
                chk(req_write === m_write, "R4 req_write", 64'(req_write), 64'(m_write));
                chk(req_cond === m_cond, "R5 req_cond", 64'(req_cond), 64'(m_cond));
                chk(req_addr === m_addr, "R3 req_addr", 64'(req_addr), 64'(m_addr));
                chk(req_wdata === m_wdata, "R4 req_wdata", 64'(req_wdata), 64'(m_wdata));
            end
        end
    end

    // Variable-latency responder
    bit r_busy = 0; int r_cnt = 0; bit r_wr = 0, r_cond = 0;
    logic [AW-1:0] r_addr; logic [33:0] r_wd;
    always @(negedge clk) begin
        rsp_valid = 0; rsp_fail = 0; rsp_nowrite = 0;
        if (req_valid) begin
            r_busy = 1; r_cnt = latency; r_wr = req_write; r_cond = req_cond;
            r_addr = req_addr; r_wd = req_wdata;
        end else if (r_busy) begin
            if (r_cnt <= 1) begin
                rsp_valid = 1; r_busy = 0;
                rsp_fail = (r_addr == '1);
                rsp_nowrite = r_cond && r_wd[0];
                rsp_data = r_wr ? r_wd : rd_val(r_addr);
            end else r_cnt--;
        end
    end

    task automatic do_scan(input logic [1:0] op, input logic [33:0] d, input logic [AW-1:0] a,
                           input string tag, output logic [W-1:0] got);
        logic [W-1:0] sin;
        sin = {a, d, op};
        @(negedge clk);
        sel_scan = 1; dr_capture = 1;
        cur_op = op; cur_data = d; cur_addr = a;
        @(negedge clk);
        dr_capture = 0; dr_shift = 1;
        for (int i = 0; i < W; i++) begin
            got[i] = tdo; tdi = sin[i];
            @(negedge clk);
        end
        dr_shift = 0; dr_update = 1;
        @(negedge clk);
        dr_update = 0; sel_scan = 0;
        chk(got === m_cap, tag, 64'(got), 64'(m_cap));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [W-1:0] g, g2;
    logic [31:0] gi;
    int tries, nreq_before;

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        chk(req_valid === 1'b0, "R9 req_valid low", 64'(req_valid), 0);
        do_scan(2'd0, 34'h0, '0, "R9 reset capture", g);
        chk(g === '0, "R9 reset capture value", 64'(g), 0);

        // R1 info register
        @(negedge clk); sel_info = 1; dr_capture = 1;
        @(negedge clk); dr_capture = 0; dr_shift = 1;
        for (int i = 0; i < 32; i++) begin gi[i] = tdo; tdi = 1'b1; @(negedge clk); end
        dr_shift = 0; sel_info = 0;
        chk(gi === 32'h0000_0061, "R1 info value", 64'(gi), 64'h61);
        chk(req_valid === 1'b0, "R1 no request from info", 64'(req_valid), 0);

        // R4 write then R6 success
        latency = 3;
        do_scan(2'd2, 34'h2_1234_5678, 6'd5, "R4 write scan", g);
        idle(10);
        do_scan(2'd0, 34'h0, '0, "R6 after write", g);
        chk(g === {6'd5, 34'h2_1234_5678, 2'd0}, "R6 write result", 64'(g), 64'({6'd5, 34'h2_1234_5678, 2'd0}));

        // R3 read, value appears one scan later (R2 layout)
        do_scan(2'd1, 34'h0, 6'd9, "R3 read scan", g);
        idle(10);
        do_scan(2'd0, 34'h0, '0, "R2 read collect", g);
        chk(g === {6'd9, rd_val(6'd9), 2'd0}, "R2 read layout", 64'(g), 64'({6'd9, rd_val(6'd9), 2'd0}));

        // R6 failing address
        do_scan(2'd1, 34'h0, 6'h3F, "R6 fail read", g);
        idle(10);
        do_scan(2'd0, 34'h0, '0, "R6 fail collect", g);
        chk(g[1:0] === 2'd2, "R6 fail status", 64'(g[1:0]), 2);

        // R5 conditional writes
        do_scan(2'd3, 34'h0_0000_0011, 6'd4, "R5 cwrite declined", g);
        idle(10);
        do_scan(2'd0, 34'h0, '0, "R5 declined collect", g);
        chk(g[1:0] === 2'd1, "R5 nowrite status", 64'(g[1:0]), 1);
        do_scan(2'd3, 34'h0_0000_0010, 6'd4, "R5 cwrite accepted", g);
        idle(10);
        do_scan(2'd0, 34'h0, '0, "R5 accepted collect", g);
        chk(g[1:0] === 2'd0, "R5 accepted status", 64'(g[1:0]), 0);

        // R7 busy and retry
        latency = 120;
        do_scan(2'd1, 34'h0, 6'd7, "R7 slow read", g);
        latency = 3;
        nreq_before = m_nreq;
        do_scan(2'd2, 34'h1_5555_AAAA, 6'd2, "R7 first retry", g);
        chk(g[1:0] === 2'd3, "R7 busy status", 64'(g[1:0]), 3);
        chk(m_nreq == nreq_before, "R7 dropped update", 64'(m_nreq), 64'(nreq_before));
        tries = 0;
        while (g[1:0] == 2'd3 && tries < 10) begin
            do_scan(2'd2, 34'h1_5555_AAAA, 6'd2, "R7 retry", g);
            tries++;
        end
        chk(g === {6'd7, rd_val(6'd7), 2'd0}, "R7 result after busy", 64'(g), 64'({6'd7, rd_val(6'd7), 2'd0}));
        chk(m_nreq == nreq_before + 1, "R7 one write issued", 64'(m_nreq), 64'(nreq_before + 1));
        idle(10);

        // R8 no-op keeps result
        do_scan(2'd0, 34'h3_FFFF_FFFF, 6'd1, "R8 nop one", g);
        idle(5);
        nreq_before = m_nreq;
        do_scan(2'd0, 34'h0, 6'd3, "R8 nop two", g2);
        chk(g2 === g, "R8 stable result", 64'(g2), 64'(g));
        chk(g === {6'd2, 34'h1_5555_AAAA, 2'd0}, "R8 last write", 64'(g), 64'({6'd2, 34'h1_5555_AAAA, 2'd0}));
        idle(5);
        chk(m_nreq == nreq_before, "R8 no request", 64'(m_nreq), 64'(nreq_before));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule